// File: doc/BRIEF.md
# Adaptive Context Probability Tracker

This block holds the adaptive probability state of every coding context of a binary arithmetic encoder. Each context owns a small state: an index into a fixed probability estimation table and the sense of its more probable symbol (MPS). A context/decision pair enters on a valid/ready stream. The block reads the context's state and looks up the table row for that index. It then classifies the decision as MPS or LPS (less probable symbol), emits the row's probability estimate (Qe) together with that classification, and writes the adapted state back.

The context store is a registered-read memory, so a pair and its successor overlap in the pipeline. When consecutive pairs name the same context, the state being written is bypassed into the read so the second pair sees the adapted state. With the output side always ready, one pair is taken every cycle. The result leaves two clock edges after acceptance.

Top module: `mq_ctx_adapt`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: out_is_mps is 1 exactly when the decision bit equals the context's current MPS sense.
- R3: After an MPS, the context's index becomes the next-on-MPS entry of its current table row.
- R4: After an LPS, the context's index becomes the next-on-LPS entry of its current table row.
- R5: The MPS sense of a context flips only on an LPS whose current row has its swap flag set. In every other case it is kept.
- R6: After reset every MPS sense is 0. Context 0 starts at index 4, context 17 at index 3, context 18 at index 46, and all other contexts at index 0.
- R7: out_qe is the 16-bit Qe of the context's table row before the update caused by that pair.
- R8: With out_ready held at 1, in_ready stays 1 and a pair accepted on one edge appears on the output after the second following edge.
- R9: A pair on the same context as the pair just before it, including back-to-back, uses the state that pair produced.
- R10: While out_valid is 1 and out_ready is 0, out_qe and out_is_mps hold their values and out_valid stays 1.
- R11: Every accepted pair yields exactly one output, in acceptance order. Contexts are 0 to 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_ctx | input | 5 | Context number, 0 to 18 |
| in_dec | input | 1 | Decision bit |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_qe | output | 16 | Probability estimate of the row used |
| out_is_mps | output | 1 | 1 when the decision was coded as MPS |

## Verification
The bench builds the block with its default of 19 contexts, so each of the distinct starting indices is reachable, including the self-looping index 46. Long same-context runs of random decisions walk the index into the deep table states such as 45 and back through swap rows. Repeated contexts under random downstream stalls exercise the bypass path in the cycles where a write and a read of the same context coincide.

// File: rtl/mqa_pkg.sv
`timescale 1ns/1ps
package mqa_pkg;
    localparam int CTX_COUNT = 19;
    localparam int ST_COUNT  = 47;
    localparam int IDX_W     = $clog2(ST_COUNT);
    localparam int QE_W      = 16;

    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        idx_t idx;
        logic sense;
    } ctx_state_t;

    typedef struct packed {
        logic [QE_W-1:0] qe;
        idx_t            nmps;
        idx_t            nlps;
        logic            swap;
    } prob_row_t;

    function automatic prob_row_t mk(input logic [QE_W-1:0] q, input int nm,
                                     input int nl, input logic sw);
        prob_row_t r;
        r.qe   = q;
        r.nmps = idx_t'(nm);
        r.nlps = idx_t'(nl);
        r.swap = sw;
        return r;
    endfunction

    function automatic prob_row_t prob_row(input idx_t i);
        case (i)
            6'd0:  return mk(16'h5601,  1,  1, 1'b1);
            6'd1:  return mk(16'h3401,  2,  6, 1'b0);
            6'd2:  return mk(16'h1801,  3,  9, 1'b0);
            6'd3:  return mk(16'h0AC1,  4, 12, 1'b0);
            6'd4:  return mk(16'h0521,  5, 29, 1'b0);
            6'd5:  return mk(16'h0221, 38, 33, 1'b0);
            6'd6:  return mk(16'h5601,  7,  6, 1'b1);
            6'd7:  return mk(16'h5401,  8, 14, 1'b0);
            6'd8:  return mk(16'h4801,  9, 14, 1'b0);
            6'd9:  return mk(16'h3801, 10, 14, 1'b0);
            6'd10: return mk(16'h3001, 11, 17, 1'b0);
            6'd11: return mk(16'h2401, 12, 18, 1'b0);
            6'd12: return mk(16'h1C01, 13, 20, 1'b0);
            6'd13: return mk(16'h1601, 29, 21, 1'b0);
            6'd14: return mk(16'h5601, 15, 14, 1'b1);
            6'd15: return mk(16'h5401, 16, 14, 1'b0);
            6'd16: return mk(16'h5101, 17, 15, 1'b0);
            6'd17: return mk(16'h4801, 18, 16, 1'b0);
            6'd18: return mk(16'h3801, 19, 17, 1'b0);
            6'd19: return mk(16'h3401, 20, 18, 1'b0);
            6'd20: return mk(16'h3001, 21, 19, 1'b0);
            6'd21: return mk(16'h2801, 22, 19, 1'b0);
            6'd22: return mk(16'h2401, 23, 20, 1'b0);
            6'd23: return mk(16'h2201, 24, 21, 1'b0);
            6'd24: return mk(16'h1C01, 25, 22, 1'b0);
            6'd25: return mk(16'h1801, 26, 23, 1'b0);
            6'd26: return mk(16'h1601, 27, 24, 1'b0);
            6'd27: return mk(16'h1401, 28, 25, 1'b0);
            6'd28: return mk(16'h1201, 29, 26, 1'b0);
            6'd29: return mk(16'h1101, 30, 27, 1'b0);
            6'd30: return mk(16'h0AC1, 31, 28, 1'b0);
            6'd31: return mk(16'h09C1, 32, 29, 1'b0);
            6'd32: return mk(16'h08A1, 33, 30, 1'b0);
            6'd33: return mk(16'h0521, 34, 31, 1'b0);
            6'd34: return mk(16'h0441, 35, 32, 1'b0);
            6'd35: return mk(16'h02A1, 36, 33, 1'b0);
            6'd36: return mk(16'h0221, 37, 34, 1'b0);
            6'd37: return mk(16'h0141, 38, 35, 1'b0);
            6'd38: return mk(16'h0111, 39, 36, 1'b0);
            6'd39: return mk(16'h0085, 40, 37, 1'b0);
            6'd40: return mk(16'h0049, 41, 38, 1'b0);
            6'd41: return mk(16'h0025, 42, 39, 1'b0);
            6'd42: return mk(16'h0015, 43, 40, 1'b0);
            6'd43: return mk(16'h0009, 44, 41, 1'b0);
            6'd44: return mk(16'h0005, 45, 42, 1'b0);
            6'd45: return mk(16'h0001, 45, 43, 1'b0);
            6'd46: return mk(16'h5601, 46, 46, 1'b0);
            default: return mk(16'h5601, 46, 46, 1'b0);
        endcase
    endfunction

    // starting index of each context after reset
    function automatic idx_t start_idx(input int c);
        if (c == 0)  return idx_t'(4);
        if (c == 17) return idx_t'(3);
        if (c == 18) return idx_t'(46);
        return idx_t'(0);
    endfunction
endpackage

// File: rtl/mqa_prob_rom.sv
`timescale 1ns/1ps
module mqa_prob_rom
    import mqa_pkg::*;
(
    input  idx_t      idx,
    output prob_row_t row
);
    always_comb row = prob_row(idx);
endmodule

// File: rtl/mqa_next_state.sv
`timescale 1ns/1ps
module mqa_next_state
    import mqa_pkg::*;
(
    input  ctx_state_t cur,
    input  logic       dec,
    input  prob_row_t  row,
    output logic       is_mps,
    output ctx_state_t nxt
);
    always_comb begin
        is_mps = (dec == cur.sense);
        nxt    = cur;
        if (is_mps) begin
            nxt.idx = row.nmps;
        end else begin
            nxt.idx = row.nlps;
            if (row.swap) nxt.sense = ~cur.sense;
        end
    end
endmodule

// File: rtl/mqa_ctx_mem.sv
`timescale 1ns/1ps
module mqa_ctx_mem
    import mqa_pkg::*;
#(
    parameter int NUM_CTX = CTX_COUNT,
    localparam int CTX_W  = $clog2(NUM_CTX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTX_W-1:0] wr_ctx,
    input  ctx_state_t       wr_state,
    input  logic             rd_en,
    input  logic [CTX_W-1:0] rd_ctx,
    output ctx_state_t       rd_state
);
    localparam logic [CTX_W-1:0] LAST_CTX = CTX_W'(NUM_CTX - 1);

    ctx_state_t mem [NUM_CTX];
    ctx_state_t stored;
    logic       bypass;

    always_comb begin
        stored = '0;
        if (rd_ctx <= LAST_CTX) stored = mem[rd_ctx];
        bypass = wr_en && (wr_ctx == rd_ctx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_CTX; k++) begin
                mem[k].idx   <= start_idx(k);
                mem[k].sense <= 1'b0;
            end
        end else if (wr_en && (wr_ctx <= LAST_CTX)) begin
            mem[wr_ctx] <= wr_state;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_state <= '0;
        else if (rd_en) rd_state <= bypass ? wr_state : stored;
    end

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_state.idx) < ST_COUNT));
endmodule

// File: rtl/mq_ctx_adapt.sv
`timescale 1ns/1ps
module mq_ctx_adapt
    import mqa_pkg::*;
#(
    parameter int NUM_CTX = CTX_COUNT,
    localparam int CTX_W  = $clog2(NUM_CTX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [CTX_W-1:0] in_ctx,
    input  logic             in_dec,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [QE_W-1:0]  out_qe,
    output logic             out_is_mps
);
    logic             s1_valid;
    logic [CTX_W-1:0] s1_ctx;
    logic             s1_dec;
    logic             out_adv, s1_go, in_fire;
    ctx_state_t       cur, nxt;
    prob_row_t        row;
    logic             is_mps;

    assign out_adv  = !out_valid || out_ready;
    assign s1_go    = s1_valid && out_adv;
    assign in_ready = !s1_valid || out_adv;
    assign in_fire  = in_valid && in_ready;

    mqa_ctx_mem #(.NUM_CTX(NUM_CTX)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (s1_go),
        .wr_ctx   (s1_ctx),
        .wr_state (nxt),
        .rd_en    (in_fire),
        .rd_ctx   (in_ctx),
        .rd_state (cur)
    );

    mqa_prob_rom u_rom (
        .idx (cur.idx),
        .row (row)
    );

    mqa_next_state u_next (
        .cur    (cur),
        .dec    (s1_dec),
        .row    (row),
        .is_mps (is_mps),
        .nxt    (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_ctx   <= '0;
            s1_dec   <= 1'b0;
        end else if (in_ready) begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_ctx <= in_ctx;
                s1_dec <= in_dec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_qe     <= '0;
            out_is_mps <= 1'b0;
        end else if (out_adv) begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_qe     <= row.qe;
                out_is_mps <= is_mps;
            end
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_qe) && $stable(out_is_mps)));

    // R8
    drain_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && out_ready) |=> out_valid);

    // R5
    sense_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_go && (is_mps || !row.swap)) |-> (nxt.sense == cur.sense));
endmodule

// File: tb/tb_mq_ctx_adapt.sv
`timescale 1ns/1ps
module tb_mq_ctx_adapt;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [4:0]  in_ctx = '0;
    logic        in_dec = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_qe;
    logic        out_is_mps;

    int checks = 0;
    int errors = 0;

    mq_ctx_adapt dut (.*);

    always #5 clk = ~clk;

    // reference model state
    int          m_idx   [19];
    logic        m_sense [19];
    logic [16:0] exp_q   [$];
    string       tag_q   [$];
    string       phase = "R6";
    logic        prev_stall = 1'b0;
    logic [16:0] held;

    function automatic logic [28:0] ref_row(input int i);
        case (i)
            0:  return {16'h5601, 6'd1,  6'd1,  1'b1};
            1:  return {16'h3401, 6'd2,  6'd6,  1'b0};
            2:  return {16'h1801, 6'd3,  6'd9,  1'b0};
            3:  return {16'h0AC1, 6'd4,  6'd12, 1'b0};
            4:  return {16'h0521, 6'd5,  6'd29, 1'b0};
            5:  return {16'h0221, 6'd38, 6'd33, 1'b0};
            6:  return {16'h5601, 6'd7,  6'd6,  1'b1};
            7:  return {16'h5401, 6'd8,  6'd14, 1'b0};
            8:  return {16'h4801, 6'd9,  6'd14, 1'b0};
            9:  return {16'h3801, 6'd10, 6'd14, 1'b0};
            10: return {16'h3001, 6'd11, 6'd17, 1'b0};
            11: return {16'h2401, 6'd12, 6'd18, 1'b0};
            12: return {16'h1C01, 6'd13, 6'd20, 1'b0};
            13: return {16'h1601, 6'd29, 6'd21, 1'b0};
            14: return {16'h5601, 6'd15, 6'd14, 1'b1};
            15: return {16'h5401, 6'd16, 6'd14, 1'b0};
            16: return {16'h5101, 6'd17, 6'd15, 1'b0};
            17: return {16'h4801, 6'd18, 6'd16, 1'b0};
            18: return {16'h3801, 6'd19, 6'd17, 1'b0};
            19: return {16'h3401, 6'd20, 6'd18, 1'b0};
            20: return {16'h3001, 6'd21, 6'd19, 1'b0};
            21: return {16'h2801, 6'd22, 6'd19, 1'b0};
            22: return {16'h2401, 6'd23, 6'd20, 1'b0};
            23: return {16'h2201, 6'd24, 6'd21, 1'b0};
            24: return {16'h1C01, 6'd25, 6'd22, 1'b0};
            25: return {16'h1801, 6'd26, 6'd23, 1'b0};
            26: return {16'h1601, 6'd27, 6'd24, 1'b0};
            27: return {16'h1401, 6'd28, 6'd25, 1'b0};
            28: return {16'h1201, 6'd29, 6'd26, 1'b0};
            29: return {16'h1101, 6'd30, 6'd27, 1'b0};
            30: return {16'h0AC1, 6'd31, 6'd28, 1'b0};
            31: return {16'h09C1, 6'd32, 6'd29, 1'b0};
            32: return {16'h08A1, 6'd33, 6'd30, 1'b0};
            33: return {16'h0521, 6'd34, 6'd31, 1'b0};
            34: return {16'h0441, 6'd35, 6'd32, 1'b0};
            35: return {16'h02A1, 6'd36, 6'd33, 1'b0};
            36: return {16'h0221, 6'd37, 6'd34, 1'b0};
            37: return {16'h0141, 6'd38, 6'd35, 1'b0};
            38: return {16'h0111, 6'd39, 6'd36, 1'b0};
            39: return {16'h0085, 6'd40, 6'd37, 1'b0};
            40: return {16'h0049, 6'd41, 6'd38, 1'b0};
            41: return {16'h0025, 6'd42, 6'd39, 1'b0};
            42: return {16'h0015, 6'd43, 6'd40, 1'b0};
            43: return {16'h0009, 6'd44, 6'd41, 1'b0};
            44: return {16'h0005, 6'd45, 6'd42, 1'b0};
            45: return {16'h0001, 6'd45, 6'd43, 1'b0};
            default: return {16'h5601, 6'd46, 6'd46, 1'b0};
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R6: starting state of each context
    task automatic model_reset();
        for (int c = 0; c < 19; c++) begin
            m_sense[c] = 1'b0;
            m_idx[c]   = (c == 0) ? 4 : (c == 17) ? 3 : (c == 18) ? 46 : 0;
        end
        exp_q.delete();
        tag_q.delete();
        prev_stall = 1'b0;
    endtask

    task automatic model_accept(input int c, input logic d);
        logic [28:0] r;
        logic        mps;
        r   = ref_row(m_idx[c]);
        mps = (d == m_sense[c]);
        exp_q.push_back({r[28:13], mps});
        tag_q.push_back({phase, mps ? " R2 R7 R3" : " R2 R7 R4"});
        if (mps) begin
            m_idx[c] = int'(r[12:7]);
        end else begin
            m_idx[c] = int'(r[6:1]);
            if (r[0]) m_sense[c] = ~m_sense[c];
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        // R1: during reset
        @(negedge clk);
        check(!out_valid && in_ready, "R1 in reset", {out_valid, in_ready}, 2'b01);
        rst = 1'b0;
        model_reset();
        @(posedge clk);
        @(negedge clk);
        #1;
        check(!out_valid && in_ready, "R1 after reset", {out_valid, in_ready}, 2'b01);
    endtask

    // one cycle: drive at the falling edge, evaluate handshakes, then the rising edge
    task automatic step(input bit v, input int c, input logic d, input bit ordy);
        @(negedge clk);
        in_valid  = v;
        in_ctx    = 5'(c);
        in_dec    = d;
        out_ready = ordy;
        #1;
        if (prev_stall) begin
            // R10: held result
            check(out_valid && ({out_qe, out_is_mps} == held), "R10 stall hold",
                  {14'd0, out_valid, out_qe, out_is_mps}, {14'd0, 1'b1, held});
        end
        if (in_valid && in_ready) model_accept(c, d);
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected output", {15'd0, out_qe, out_is_mps}, 32'd0);
            end else begin
                logic [16:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({out_qe, out_is_mps} == e, t, {15'd0, out_qe, out_is_mps}, {15'd0, e});
            end
        end
        prev_stall = out_valid && !out_ready;
        held = {out_qe, out_is_mps};
    endtask

    task automatic drain();
        for (int k = 0; k < 6; k++) step(0, 0, 1'b0, 1'b1);
        check(exp_q.size() == 0, "R11 all results delivered", exp_q.size(), 0);
    endtask

    initial begin
        int          lastc;
        int unsigned seed;
        seed = $urandom(32'd2024);
        do_reset();

        // R6: first pair on every context after reset, decision 0
        phase = "R6";
        for (int c = 0; c < 19; c++) step(1, c, 1'b0, 1'b1);
        drain();

        // R8: latency of two edges
        do_reset();
        phase = "R8";
        step(1, 3, 1'b0, 1'b1);
        step(0, 0, 1'b0, 1'b1);
        check(!out_valid, "R8 not yet after one edge", out_valid, 0);
        step(0, 0, 1'b0, 1'b1);
        drain();

        // R5: context 5 at index 0 has swap set; LPS flips sense, then 1 is MPS
        phase = "R5 R9";
        step(1, 5, 1'b1, 1'b1);
        step(1, 5, 1'b1, 1'b1);
        step(1, 5, 1'b0, 1'b1);
        step(1, 5, 1'b0, 1'b1);
        drain();

        // R9: back-to-back on one context, mixed decisions
        phase = "R9";
        for (int k = 0; k < 24; k++) step(1, 17, logic'(k % 3 == 0), 1'b1);
        // R3: long MPS run to reach index 45 on context 2
        for (int k = 0; k < 40; k++) step(1, 2, 1'b0, 1'b1);
        drain();

        // R8: full rate, in_ready stays high
        phase = "R8";
        for (int k = 0; k < 40; k++) begin
            step(1, k % 19, logic'($urandom_range(1, 0)), 1'b1);
            check(in_ready, "R8 in_ready at full rate", in_ready, 1);
        end
        drain();

        // R10 R11: random pairs with downstream stalls
        phase = "R10 R11";
        lastc = 0;
        for (int k = 0; k < 3000; k++) begin
            int c;
            c = ($urandom_range(9, 0) < 4) ? lastc : int'($urandom_range(18, 0));
            lastc = c;
            step(($urandom_range(4, 0) != 0), c, logic'($urandom_range(3, 0) == 0),
                 ($urandom_range(3, 0) != 0));
        end
        drain();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule